// File: doc/BRIEF.md
# Serial-In Shift Register with Strobed Output Latch

This block takes a single-bit serial stream into an eight-stage shift chain. Each stage moves one position on every rising clock edge. Every stage also feeds a holding latch. The strobe input controls that latch. While strobe is high the latch is open, so the parallel outputs follow the live shift contents. When strobe falls, the latch captures the current contents and keeps them until strobe rises again. This lets a controller shift a new word in without disturbing the word already presented on the parallel pins.

The parallel side is not a tri-state bus. It is a data vector with a matching per-bit drive-enable vector. When output enable is low, every enable bit is low and the data bits are forced to zero, which stands for the high-impedance state. The last stage drives a serial output that can feed the next device in a chain. A second serial output copies that bit on the following falling clock edge, which gives a half-cycle of extra hold for a cascade clocked on a skewed edge.

The strobe is sampled with the clock. A capture takes the contents present at the last rising edge at which strobe was seen high. The latch has two modes, derived from the strobe level:
- OPEN: strobe is high, the outputs follow the chain, and the latch reloads at each edge.
- HOLD: strobe is low and the latch keeps its value.

The strobe-fall transition (OPEN to HOLD) freezes the word. The strobe-rise transition (HOLD to OPEN) reconnects the outputs to the chain.

Top module: `serial_latch_reg`

## Requirements
- R1: A rising clock edge with rst_n low clears all shift stages, all latches and the secondary serial output to 0; after the falling edge that follows, ser_out and ser_out_dly are 0.
- R2: On each rising clock edge, stage 1 takes ser_in and stage N takes the previous value of stage N-1. Stage 1 is bit 0 and stage 8 is bit 7 of the parallel vector.
- R3: ser_out always equals stage 8, whatever the levels of strobe and out_en.
- R4: ser_out_dly takes the value of ser_out at each falling clock edge and holds it through the next rising edge.
- R5: While strobe is high (OPEN mode) and out_en is high, par_data equals the current shift stages.
- R6: From a strobe fall (OPEN to HOLD) until strobe rises again, par_data keeps the stage contents of the last rising edge at which strobe was high, across any number of shifts.
- R7: While out_en is low, par_oe is all zeros and par_data is all zeros (high-impedance). While out_en is high, par_oe is all ones.
- R8: out_en has no effect on the shift chain, the serial outputs or the latch contents. Stages shifted in while out_en is low appear when out_en returns high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; the chain shifts on the rising edge and the secondary tap updates on the falling edge |
| rst_n | input | 1 | Synchronous active-low reset |
| ser_in | input | 1 | Serial data into stage 1 |
| strobe | input | 1 | High opens the latch; low holds it |
| out_en | input | 1 | High drives the parallel outputs |
| par_data | output | 8 | Latched parallel data, zero while undriven |
| par_oe | output | 8 | Per-bit drive enable for par_data |
| ser_out | output | 1 | Stage 8, used for cascading |
| ser_out_dly | output | 1 | ser_out re-timed to the falling clock edge |

## Verification
The hardest case to reach from the ports is a held word that stays put while the chain behind it is completely rewritten. The bench loads a known word with strobe high and drops strobe. It then shifts eight or more bits of a contrasting pattern, some of them with out_en low. At every cycle it compares the parallel outputs with the captured word, not with the live chain. The half-cycle tap is checked on both sides of the falling edge: just after the rising edge it must still show the old stage 8, and just after the falling edge it must show the new one.

// File: rtl/srl_pkg.sv
package srl_pkg;

    // Latch mode, derived from the strobe level
    typedef enum logic {
        LATCH_HOLD = 1'b0,
        LATCH_OPEN = 1'b1
    } latch_mode_e;

endpackage

// File: rtl/srl_shift_chain.sv
module srl_shift_chain #(
    parameter int STAGES = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ser_in,
    output logic [STAGES-1:0] stages_q,
    output logic [STAGES-1:0] stages_d
);

    // Next chain value: bit 0 is stage 1 and takes the serial input.
    always_comb begin
        stages_d[0] = ser_in;
        for (int i = 1; i < STAGES; i++) begin
            stages_d[i] = stages_q[i-1];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stages_q <= '0;
        end else begin
            stages_q <= stages_d;
        end
    end

endmodule

// File: rtl/srl_strobe_latch.sv
module srl_strobe_latch
    import srl_pkg::*;
#(
    parameter int STAGES = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              strobe,
    input  logic [STAGES-1:0] stage_now,
    input  logic [STAGES-1:0] stage_next,
    output logic [STAGES-1:0] held_q,
    output logic [STAGES-1:0] view
);

    latch_mode_e mode;

    // Mode follows the strobe level.
    always_comb begin
        mode = strobe ? LATCH_OPEN : LATCH_HOLD;
    end

    // Holding register: reloads while open, keeps its value while held.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            held_q <= '0;
        end else begin
            unique case (mode)
                LATCH_OPEN: held_q <= stage_next;
                LATCH_HOLD: held_q <= held_q;
            endcase
        end
    end

    // Output view: transparent while open, captured word while held.
    always_comb begin
        unique case (mode)
            LATCH_OPEN: view = stage_now;
            LATCH_HOLD: view = held_q;
        endcase
    end

endmodule

// File: rtl/srl_out_gate.sv
module srl_out_gate #(
    parameter int STAGES = 8
) (
    input  logic              out_en,
    input  logic [STAGES-1:0] view,
    output logic [STAGES-1:0] par_data,
    output logic [STAGES-1:0] par_oe
);

    for (genvar b = 0; b < STAGES; b++) begin : g_bit
        assign par_oe[b]   = out_en;
        assign par_data[b] = out_en & view[b];
    end

endmodule

// File: rtl/srl_cascade_tap.sv
module srl_cascade_tap (
    input  logic clk,
    input  logic rst_n,
    input  logic last_stage,
    output logic tap_q
);

    always_ff @(negedge clk) begin
        if (!rst_n) begin
            tap_q <= 1'b0;
        end else begin
            tap_q <= last_stage;
        end
    end

endmodule

// File: rtl/serial_latch_reg.sv
module serial_latch_reg #(
    parameter int STAGES = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ser_in,
    input  logic              strobe,
    input  logic              out_en,
    output logic [STAGES-1:0] par_data,
    output logic [STAGES-1:0] par_oe,
    output logic              ser_out,
    output logic              ser_out_dly
);

    localparam int LAST = STAGES - 1;

    logic [STAGES-1:0] stages_q;
    logic [STAGES-1:0] stages_d;
    logic [STAGES-1:0] held_q;
    logic [STAGES-1:0] view;

    srl_shift_chain #(.STAGES(STAGES)) u_chain (
        .clk      (clk),
        .rst_n    (rst_n),
        .ser_in   (ser_in),
        .stages_q (stages_q),
        .stages_d (stages_d)
    );

    srl_strobe_latch #(.STAGES(STAGES)) u_latch (
        .clk        (clk),
        .rst_n      (rst_n),
        .strobe     (strobe),
        .stage_now  (stages_q),
        .stage_next (stages_d),
        .held_q     (held_q),
        .view       (view)
    );

    srl_out_gate #(.STAGES(STAGES)) u_gate (
        .out_en   (out_en),
        .view     (view),
        .par_data (par_data),
        .par_oe   (par_oe)
    );

    assign ser_out = stages_q[LAST];

    srl_cascade_tap u_tap (
        .clk        (clk),
        .rst_n      (rst_n),
        .last_stage (stages_q[LAST]),
        .tap_q      (ser_out_dly)
    );

endmodule

// File: rtl/serial_latch_reg_chk.sv
module serial_latch_reg_chk #(
    parameter int STAGES = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              ser_in,
    input logic              strobe,
    input logic              out_en,
    input logic [STAGES-1:0] par_data,
    input logic [STAGES-1:0] par_oe,
    input logic              ser_out,
    input logic              ser_out_dly,
    input logic [STAGES-1:0] stages_q,
    input logic [STAGES-1:0] held_q
);

    // R1
    reset_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!rst_n) |-> (stages_q == '0 && held_q == '0));

    // R2
    stage_one_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> stages_q[0] == $past(ser_in));

    // R2
    chain_move_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> stages_q[STAGES-1:1] == $past(stages_q[STAGES-2:0]));

    // R4
    tap_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> ser_out_dly == ser_out);

    // R6
    held_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(!strobe)) |-> $stable(held_q));

    // R7
    undriven_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !out_en |-> (par_oe == '0 && par_data == '0));

    // R7
    driven_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_en |-> $countones(par_oe) == STAGES);

endmodule

bind serial_latch_reg serial_latch_reg_chk #(.STAGES(STAGES)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .ser_in      (ser_in),
    .strobe      (strobe),
    .out_en      (out_en),
    .par_data    (par_data),
    .par_oe      (par_oe),
    .ser_out     (ser_out),
    .ser_out_dly (ser_out_dly),
    .stages_q    (stages_q),
    .held_q      (held_q)
);

// File: tb/serial_latch_reg_test.sv
module serial_latch_reg_test;

    localparam int STAGES = 8;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              ser_in = 1'b0;
    logic              strobe = 1'b0;
    logic              out_en = 1'b0;
    logic [STAGES-1:0] par_data;
    logic [STAGES-1:0] par_oe;
    logic              ser_out;
    logic              ser_out_dly;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    logic [STAGES-1:0] m_chain = '0;
    logic [STAGES-1:0] m_held  = '0;

    serial_latch_reg #(.STAGES(STAGES)) uut (
        .clk, .rst_n, .ser_in, .strobe, .out_en,
        .par_data, .par_oe, .ser_out, .ser_out_dly
    );

    always #4 clk = ~clk;

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // One rising edge with the given serial bit; the model tracks the chain and latch.
    task automatic step(input logic din);
        ser_in = din;
        @(posedge clk);
        m_chain = {m_chain[STAGES-2:0], din};
        if (strobe) m_held = m_chain;
        #1;
    endtask

    task automatic t_reset();
        rst_n = 1'b0; strobe = 1'b1; out_en = 1'b1;
        step(1'b1);
        m_chain = '0; m_held = '0;
        step(1'b1);
        m_chain = '0; m_held = '0;
        @(negedge clk); #1;
        // R1
        check(par_data == '0, "R1 par_data", 32'(par_data), 0);
        check(ser_out == 1'b0, "R1 ser_out", 32'(ser_out), 0);
        check(ser_out_dly == 1'b0, "R1 ser_out_dly", 32'(ser_out_dly), 0);
        rst_n = 1'b1; strobe = 1'b0;
    endtask

    task automatic t_shift(input logic [15:0] pat);
        strobe = 1'b1; out_en = 1'b1;
        for (int i = 15; i >= 0; i--) begin
            step(pat[i]);
            // R2 R5
            check(par_data == m_chain, "R2/R5 shift view", 32'(par_data), 32'(m_chain));
            // R3
            check(ser_out == m_chain[STAGES-1], "R3 ser_out", 32'(ser_out), 32'(m_chain[STAGES-1]));
        end
    endtask

    task automatic t_tap();
        logic old_last;
        strobe = 1'b1; out_en = 1'b1;
        for (int i = 0; i < 10; i++) begin
            old_last = m_chain[STAGES-1];
            step(i[0] ^ i[2]);
            // R4: no update before the falling edge
            check(ser_out_dly == old_last, "R4 before fall", 32'(ser_out_dly), 32'(old_last));
            @(negedge clk); #1;
            check(ser_out_dly == m_chain[STAGES-1], "R4 after fall", 32'(ser_out_dly), 32'(m_chain[STAGES-1]));
        end
    endtask

    task automatic t_hold();
        logic [STAGES-1:0] word;
        strobe = 1'b1; out_en = 1'b1;
        for (int i = 0; i < STAGES; i++) step(i[0]);   // 0,1,0,1...
        word = m_chain;
        strobe = 1'b0;
        #1;
        check(par_data == word, "R6 capture", 32'(par_data), 32'(word));
        for (int i = 0; i < 11; i++) begin
            step(~i[0]);
            // R6
            check(par_data == word, "R6 hold across shift", 32'(par_data), 32'(word));
        end
        strobe = 1'b1; #1;
        check(par_data == m_chain, "R5 reopen", 32'(par_data), 32'(m_chain));
    endtask

    task automatic t_outen();
        logic [STAGES-1:0] word;
        strobe = 1'b1; out_en = 1'b1;
        for (int i = 0; i < STAGES; i++) step(i < 3);
        word = m_chain;
        strobe = 1'b0;
        out_en = 1'b0;
        #1;
        // R7
        check(par_oe == '0, "R7 oe low", 32'(par_oe), 0);
        check(par_data == '0, "R7 data hi-z", 32'(par_data), 0);
        for (int i = 0; i < 5; i++) begin
            step(1'b1);
            // R8
            check(ser_out == m_chain[STAGES-1], "R8 ser_out while off", 32'(ser_out), 32'(m_chain[STAGES-1]));
            check(par_oe == '0, "R7 oe stays low", 32'(par_oe), 0);
        end
        out_en = 1'b1; #1;
        check(par_oe == '1, "R7 oe high", 32'(par_oe), 32'({STAGES{1'b1}}));
        check(par_data == word, "R8 held word kept", 32'(par_data), 32'(word));
        out_en = 1'b0; strobe = 1'b1;
        step(1'b0); step(1'b1);
        out_en = 1'b1; #1;
        check(par_data == m_chain, "R8 shifted while off", 32'(par_data), 32'(m_chain));
    endtask

    initial begin
        #(8 * 20000);
        if (!done) begin
            failures++; checks++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        #2;
        t_reset();
        t_shift(16'hA5C3);
        t_shift(16'h0FF0);
        t_tap();
        t_hold();
        t_outen();
        t_reset();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule